// File: doc/BRIEF.md
# Multiphase Sine PWM Generator

This block drives several PWM pins (three by default) whose duty cycles follow a sampled sine curve held in a small on-chip sample table. A free-running carrier counter defines the PWM period. Each pin is high from the start of a carrier period until the counter reaches that pin's compare value. A separate step-rate timer, not tied to the carrier, produces duty-update events. At each event every phase fetches its next table sample with no processor involvement. The sample goes into a shadow register and becomes the live compare value at the next carrier wrap.

All phases share one playback position. Each phase adds its own start offset to that position, modulo the table depth. A phase therefore plays from its offset to the table end, then from entry zero up to its offset, and then repeats. Phase shift is set by the offset alone. Output frequency is set by the single step-rate reload value. Software fills or edits the table through a simple write port, and may do so while the block runs.

Top module: `sinepwm_gen`

## Requirements
- R1: Phase p's pin is high while the carrier count is below its compare value and low otherwise. A compare of 0 keeps the pin low for the whole period. A compare above PERIOD_MAX keeps it high for the whole period. The pin rises only when the count is 0.
- R2: The carrier counter starts at 0 after reset. It counts up by one per clock to PERIOD_MAX, then wraps to 0, giving a period of PERIOD_MAX+1 cycles.
- R3: The step-rate timer fires an update event every R+1 cycles, where R is its active reload value. The step_reload input is captured as the active value during reset and again at every update event, so a new value governs the interval that starts at the next event.
- R4: The sample fetched at an update event sits in the phase's shadow register from two cycles after the event. It becomes the compare value at the clock edge where the carrier wraps from PERIOD_MAX to 0. The compare value never changes at any other edge.
- R5: The shared position is 0 after reset and advances by one per update event, wrapping from DEPTH-1 to 0. At an event, phase p reads entry (position + offset_p) mod DEPTH, where offset_p is bits [p*ADDR_W +: ADDR_W] of phase_offs. The first event after reset therefore reads entry offset_p. An offset change is used from the next event on.
- R6: upd_strobe is high for exactly the one cycle after each update event and low otherwise.
- R7: A table write with tbl_we high stores tbl_wdata at tbl_addr on that clock edge, in or out of reset. A fetch at the same edge returns the entry's previous contents.
- R8: Synchronous reset clears the carrier counter, the step-rate counter, the position, the fetched samples, the shadows and the compares. All pins and upd_strobe are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | ADDR_W (8) | Table write address |
| tbl_wdata | input | DATA_W (16) | Table write data |
| phase_offs | input | NUM_PHASES*ADDR_W (24) | Packed start offsets, phase p in bits [p*ADDR_W +: ADDR_W] |
| step_reload | input | RATE_W (16) | Step-rate reload value; update interval is value+1 cycles |
| pwm_out | output | NUM_PHASES (3) | PWM pins, bit p for phase p |
| upd_strobe | output | 1 | One-cycle pulse after each duty-update event |

## Verification
The latencies are fixed and the checks follow them. The pins respond combinationally in the same cycle the carrier count or the compare changes. upd_strobe rises one cycle after the event cycle. A fetched sample reaches its shadow two cycles after the event and only reaches a pin after the next carrier wrap. The bench keeps a behavioural model that is advanced at each rising edge with the same inputs the design sees. It compares every pin and the strobe at each falling edge, so each result is checked in the cycle it becomes due. Directed checks add the reset state, strobe spacing for several reload values, and pin rising edges landing exactly on carrier period starts, which the bench derives from its own count of cycles since reset.

// File: rtl/sinepwm_pkg.sv
package sinepwm_pkg;

   // modular add for table positions; both operands are below depth
   function automatic int unsigned wrap_add(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned depth);
      int unsigned s;
      s = a + b;
      return (s >= depth) ? (s - depth) : s;
   endfunction

endpackage

// File: rtl/sinepwm_table.sv
module sinepwm_table #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 256,
   parameter int NUM_RD = 3,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     rd_en,
   input  logic [NUM_RD*ADDR_W-1:0] raddr,
   output logic [NUM_RD*DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   // writes are accepted in and out of reset (R7)
   always_ff @(posedge clk) begin
      if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
   end

   // one registered read port per phase; NBA ordering gives old data on collision
   for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
      logic [ADDR_W-1:0] ra;
      logic [DATA_W-1:0] rq;
      assign ra = raddr[i*ADDR_W +: ADDR_W];
      always_ff @(posedge clk) begin
         if (rst)        rq <= '0;
         else if (rd_en) rq <= mem[ra];
      end
      assign rdata[i*DATA_W +: DATA_W] = rq;
   end

endmodule

// File: rtl/sinepwm_rate.sv
module sinepwm_rate #(
   parameter int RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RATE_W-1:0] reload,
   output logic              evt,
   output logic [RATE_W-1:0] cnt
);

   logic [RATE_W-1:0] rate_q;

   assign evt = !rst && (cnt == rate_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         rate_q <= reload;
      end else if (evt) begin
         cnt    <= '0;
         rate_q <= reload;
      end else begin
         cnt    <= cnt + 1'b1;
      end
   end

   // R3: counter restarts after each event
   assert_rate_restart_R3: assert property (@(posedge clk) disable iff (rst)
      evt |=> (cnt == '0));

   // R3: counter never passes the active reload value
   assert_rate_bound_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= rate_q);

endmodule

// File: rtl/sinepwm_carrier.sv
module sinepwm_carrier #(
   parameter int CNT_W      = 16,
   parameter int PERIOD_MAX = 65535
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(PERIOD_MAX);

   if (PERIOD_MAX < 1 || 64'(PERIOD_MAX) >= (64'd1 << CNT_W)) begin : g_bad_period
      $error("sinepwm_carrier: PERIOD_MAX must be in 1 .. 2**CNT_W-1");
   end

   assign wrap = (cnt == TOP);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   // R2: count stays inside the period
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
      cnt <= TOP);

   // R2: top of count is followed by zero
   assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (cnt == '0));

endmodule

// File: rtl/sinepwm_channel.sv
module sinepwm_channel #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fetch_vld,
   input  logic [DATA_W-1:0] sample,
   input  logic              wrap,
   input  logic [CNT_W-1:0]  cnt,
   output logic              pwm
);

   localparam int CMP_W = CNT_W + DATA_W;

   logic [DATA_W-1:0] shadow_q;
   logic [DATA_W-1:0] cmp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q <= '0;
         cmp_q    <= '0;
      end else begin
         if (fetch_vld) shadow_q <= sample;
         if (wrap)      cmp_q    <= shadow_q;
      end
   end

   assign pwm = ({{DATA_W{1'b0}}, cnt} < {{CNT_W{1'b0}}, cmp_q});

   // R4: compare only moves when a new period begins
   assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (cnt != '0) |-> $stable(cmp_q));

   // R1: pin is set only at the period start
   assert_pwm_rise_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm) |-> (cnt == '0));

   // R1: pin clears at its compare match or at a period start
   assert_pwm_fall_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(pwm) |-> ((cnt == '0) ||
                      (CMP_W'(cnt) == CMP_W'(cmp_q))));

endmodule

// File: rtl/sinepwm_gen.sv
module sinepwm_gen #(
   parameter int NUM_PHASES = 3,
   parameter int DATA_W     = 16,
   parameter int DEPTH      = 256,
   parameter int CNT_W      = 16,
   parameter int RATE_W     = 16,
   parameter int PERIOD_MAX = 65535,
   localparam int ADDR_W    = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         tbl_we,
   input  logic [ADDR_W-1:0]            tbl_addr,
   input  logic [DATA_W-1:0]            tbl_wdata,
   input  logic [NUM_PHASES*ADDR_W-1:0] phase_offs,
   input  logic [RATE_W-1:0]            step_reload,
   output logic [NUM_PHASES-1:0]        pwm_out,
   output logic                         upd_strobe
);

   import sinepwm_pkg::*;

   localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(DEPTH - 1);

   if (NUM_PHASES < 1) begin : g_bad_phases
      $error("sinepwm_gen: NUM_PHASES must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("sinepwm_gen: DEPTH must be at least 2");
   end

   logic                         evt;
   logic [RATE_W-1:0]            rate_cnt;
   logic [CNT_W-1:0]             car_cnt;
   logic                         car_wrap;
   logic [ADDR_W-1:0]            pos_q;
   logic                         strobe_q;
   logic [NUM_PHASES*ADDR_W-1:0] fetch_addr;
   logic [NUM_PHASES*DATA_W-1:0] fetch_data;

   sinepwm_rate #(.RATE_W(RATE_W)) u_rate (
      .clk    (clk),
      .rst    (rst),
      .reload (step_reload),
      .evt    (evt),
      .cnt    (rate_cnt)
   );

   sinepwm_carrier #(.CNT_W(CNT_W), .PERIOD_MAX(PERIOD_MAX)) u_carrier (
      .clk  (clk),
      .rst  (rst),
      .cnt  (car_cnt),
      .wrap (car_wrap)
   );

   // shared playback position
   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= evt;
         if (evt) pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      end
   end

   assign upd_strobe = strobe_q;

   sinepwm_table #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_RD(NUM_PHASES)) u_table (
      .clk   (clk),
      .rst   (rst),
      .we    (tbl_we),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .rd_en (evt),
      .raddr (fetch_addr),
      .rdata (fetch_data)
   );

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
      logic [ADDR_W-1:0] off;
      assign off = phase_offs[p*ADDR_W +: ADDR_W];
      assign fetch_addr[p*ADDR_W +: ADDR_W] =
         ADDR_W'(wrap_add(32'(pos_q), 32'(off), DEPTH));

      sinepwm_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chan (
         .clk       (clk),
         .rst       (rst),
         .fetch_vld (strobe_q),
         .sample    (fetch_data[p*DATA_W +: DATA_W]),
         .wrap      (car_wrap),
         .cnt       (car_cnt),
         .pwm       (pwm_out[p])
      );

      // R5: start offset must address a real entry
      assert_off_range_R5: assert property (@(posedge clk) disable iff (rst)
         32'(off) < DEPTH);
   end

   // R5: position stays inside the table
   assert_pos_range_R5: assert property (@(posedge clk) disable iff (rst)
      32'(pos_q) < DEPTH);

   // R6: strobe lines up with the restarted step-rate counter
   assert_strobe_align_R6: assert property (@(posedge clk) disable iff (rst)
      upd_strobe |-> (rate_cnt == '0));

endmodule

// File: tb/sinepwm_gen_test.sv
`timescale 1ns/1ps
module sinepwm_gen_test;

   localparam int NP   = 3;
   localparam int DW   = 16;
   localparam int D    = 256;
   localparam int AW   = 8;
   localparam int PMAX = 15;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           tbl_we = 1'b0;
   logic [AW-1:0]  tbl_addr = '0;
   logic [DW-1:0]  tbl_wdata = '0;
   logic [NP*AW-1:0] phase_offs = '0;
   logic [15:0]    step_reload = 16'd5;
   logic [NP-1:0]  pwm_out;
   logic           upd_strobe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sinepwm_gen #(.NUM_PHASES(NP), .DATA_W(DW), .DEPTH(D), .CNT_W(16),
                 .RATE_W(16), .PERIOD_MAX(PMAX)) uut (
      .clk         (clk),
      .rst         (rst),
      .tbl_we      (tbl_we),
      .tbl_addr    (tbl_addr),
      .tbl_wdata   (tbl_wdata),
      .phase_offs  (phase_offs),
      .step_reload (step_reload),
      .pwm_out     (pwm_out),
      .upd_strobe  (upd_strobe)
   );

   // behavioural reference model
   int m_cnt, m_rcnt, m_rate, m_pos, since;
   bit m_strobe;
   int m_rd[NP], m_sh[NP], m_cmp[NP];
   int tbl[D];
   bit started = 1'b0;

   always @(posedge clk) begin
      bit ev;
      started <= 1'b1;
      if (rst) begin
         m_cnt = 0; m_rcnt = 0; m_rate = int'(step_reload); m_pos = 0;
         m_strobe = 0; since = 0;
         for (int p = 0; p < NP; p++) begin m_rd[p] = 0; m_sh[p] = 0; m_cmp[p] = 0; end
      end else begin
         ev = (m_rcnt == m_rate);
         since++;
         for (int p = 0; p < NP; p++) begin
            if (m_cnt == PMAX) m_cmp[p] = m_sh[p];
            if (m_strobe) m_sh[p] = m_rd[p];
            if (ev) m_rd[p] = tbl[(m_pos + int'(phase_offs[p*AW +: AW])) % D];
         end
         m_strobe = ev;
         m_cnt = (m_cnt == PMAX) ? 0 : m_cnt + 1;
         if (ev) begin
            m_pos  = (m_pos + 1) % D;
            m_rcnt = 0;
            m_rate = int'(step_reload);
         end else begin
            m_rcnt++;
         end
      end
      if (tbl_we) tbl[tbl_addr] = int'(tbl_wdata);
   end

   // per-cycle comparison at the falling edge
   bit prev_pwm[NP];
   always @(negedge clk) begin
      if (started && !done) begin
         for (int p = 0; p < NP; p++) begin
            bit exp_pwm;
            exp_pwm = (m_cnt < m_cmp[p]);
            checks++;
            if (pwm_out[p] !== exp_pwm) begin
               errors++;
               $display("FAIL R1 R4 R5 R7 phase %0d t=%0t: pwm=%b expected %b",
                        p, $time, pwm_out[p], exp_pwm);
            end
            // R2: rising edges land on period starts counted since reset
            if (!rst && pwm_out[p] && !prev_pwm[p]) begin
               checks++;
               if ((since % (PMAX + 1)) != 0) begin
                  errors++;
                  $display("FAIL R2 phase %0d: rise at period phase %0d expected 0",
                           p, since % (PMAX + 1));
               end
            end
            prev_pwm[p] = pwm_out[p];
         end
         checks++;
         if (upd_strobe !== m_strobe) begin
            errors++;
            $display("FAIL R6 t=%0t: upd_strobe=%b expected %b", $time, upd_strobe, m_strobe);
         end
      end
   end

   task automatic finish_sim();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fill_table(input int mul, input int add, input int modv);
      for (int i = 0; i < D; i++) begin
         @(negedge clk);
         tbl_we    = 1'b1;
         tbl_addr  = AW'(i);
         tbl_wdata = DW'((i * mul + add) % modv);
      end
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // R3 directed: spacing between consecutive strobes
   task automatic measure_interval(input int expected);
      int n;
      @(negedge clk);
      while (!upd_strobe) @(negedge clk);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!upd_strobe && n < 100000);
      checks++;
      if (n != expected) begin
         errors++;
         $display("FAIL R3 strobe interval %0d expected %0d", n, expected);
      end
   endtask

   // R8 directed: outputs cleared in reset
   task automatic check_reset_low();
      checks++;
      if (pwm_out !== '0 || upd_strobe !== 1'b0) begin
         errors++;
         $display("FAIL R8 reset outputs pwm=%b strobe=%b expected 000 0",
                  pwm_out, upd_strobe);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_sim();
   end

   initial begin
      rst = 1'b1;
      step_reload = 16'd5;
      phase_offs = {8'd170, 8'd85, 8'd0};
      // R7: table written during reset; values span 0 and beyond PMAX (R1)
      fill_table(13, 0, 21);
      check_reset_low();
      @(negedge clk);
      rst = 1'b0;
      run(300);
      measure_interval(6);
      step_reload = 16'd2;
      run(200);
      measure_interval(3);
      // R5: new offsets, including wrap at the table end
      phase_offs = {8'd128, 8'd255, 8'd3};
      run(200);
      // R7: rewrite the whole table while running
      fill_table(5, 3, 19);
      run(200);
      step_reload = 16'd0;
      run(100);
      measure_interval(1);
      step_reload = 16'd7;
      run(100);
      measure_interval(8);
      // R8: reset in the middle of operation
      @(negedge clk);
      rst = 1'b1;
      run(2);
      check_reset_low();
      rst = 1'b0;
      run(400);
      finish_sim();
   end

endmodule